// File: doc/BRIEF.md
# Multiplexed Segment LCD Scan Generator

This block is the refresh engine of a segment LCD driver with 73 segment outputs and 4 common outputs. A line strobe from the display clock steps a line pointer through display memory. At each frame boundary the pointer is reloaded from a programmable start line, so the first common always shows that line, and changing the start line scrolls the image. The block reads one 80-column row per line through a combinational read port. It latches the row, then emits a 2-bit drive-level code for every segment and common pin. The code depends on the alternating frame signal, the chosen duty (3 or 4 lines per frame) and the operating mode.

Mode inputs control the display on/off state, static drive (all commons selected at once), column reversal and master or slave operation. In master mode the frame signal is generated internally. In slave mode it is taken from a master, and each of its edges restarts the frame so that the commons stay in phase. Static drive combined with display off is a power-save state: scanning freezes and every pin is held at the VDD level. Level codes are 0 = VDD, 1 = V1, 2 = V2, 3 = V3. The analog levels themselves are produced outside the block.

Top module: `lcd_seg_scan`

## Requirements
- R1: While reset is high, and until new data is latched, every segment and common code is 0 (VDD), `fr_o` is 0 and `rd_line_o` equals `start_line_i`.
- R2: Outside power save, each `line_tick_i` pulse increments the 5-bit line pointer (31 wraps to 0). On the tick that ends a frame, the pointer instead reloads from `start_line_i`. `rd_line_o` carries the pointer: memory page = bits [4:3], bit within the byte = bits [2:0].
- R3: With `duty4_i`=1 a frame has 4 lines and commons 0 to 3 are selected in turn. With `duty4_i`=0 a frame has 3 lines and common 3 is never selected. Outside static drive, exactly one common is selected per line.
- R4: In master mode (`master_i`=1) the frame signal toggles on every frame-ending tick and holds at all other times. `fr_o` shows the frame signal used by the output codes.
- R5: In slave mode (`master_i`=0) the frame signal follows `fr_i`. A change of `fr_i` restarts the frame at common 0 and the start line. A frame-ending tick wraps without toggling the frame signal.
- R6: Segment code with frame=1 is 0 for data 1 and 2 for data 0. With frame=0 it is 3 for data 1 and 1 for data 0.
- R7: Common code with frame=1 is 3 when selected and 1 when not. With frame=0 it is 0 when selected and 2 when not.
- R8: With `reverse_i`=1, segment n shows row column 79-n. With `reverse_i`=0 it shows column n.
- R9: With `static_i`=1 and `disp_on_i`=1, all four commons are selected and segment data is shown.
- R10: With `disp_on_i`=0 and `static_i`=0, every segment is coded as data 0 while the commons keep scanning.
- R11: With `static_i`=1 and `disp_on_i`=0, every output code is 0. The line pointer, common index and frame signal hold through any ticks. Scanning resumes from the held state once either condition is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| line_tick_i | input | 1 | One-cycle line strobe |
| master_i | input | 1 | 1 = master (frame generated), 0 = slave |
| fr_i | input | 1 | Frame signal from the master, used in slave mode |
| start_line_i | input | 5 | Start-line register value |
| duty4_i | input | 1 | 1 = four lines per frame, 0 = three |
| disp_on_i | input | 1 | Display on |
| static_i | input | 1 | Static drive enable |
| reverse_i | input | 1 | Column reversal |
| rd_line_o | output | 5 | Memory line address (page = [4:3], bit = [2:0]) |
| rd_row_i | input | 80 | Row data for `rd_line_o`, column c at bit c |
| fr_o | output | 1 | Frame signal aligned with the output codes |
| seg_lvl_o | output | 146 | Segment codes, segment n at bits [2n+1:2n] |
| com_lvl_o | output | 8 | Common codes, common k at bits [2k+1:2k] |

## Verification
On every cycle the assertions check the frame sequencing: reload to the start line on a frame-ending tick, frame toggling and holding in master mode, frame following in slave mode, and the freeze of all scan state during power save. They also check that one common is selected outside static drive, that every code is VDD during power save, and that static drive selects all commons. Only the bench's scenarios can show the full level-code tables, the column mapping under reversal against known row patterns, and line-pointer wrap from 31 to 0. They also cover a frame restart caused by a slave edge in mid-frame and resumption after power save.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

    typedef enum logic [1:0] {
        LVL_VDD = 2'd0,
        LVL_V1  = 2'd1,
        LVL_V2  = 2'd2,
        LVL_V3  = 2'd3
    } lvl_e;

    typedef struct packed {
        logic fr;
        logic blank;
    } drive_ctl_t;

    function automatic lvl_e seg_level(input logic fr, input logic on);
        if (fr) return on ? LVL_VDD : LVL_V2;
        else    return on ? LVL_V3  : LVL_V1;
    endfunction

    function automatic lvl_e com_level(input logic fr, input logic sel);
        if (fr) return sel ? LVL_V3  : LVL_V1;
        else    return sel ? LVL_VDD : LVL_V2;
    endfunction

endpackage

// File: rtl/lcd_scan_timing.sv
module lcd_scan_timing #(
    parameter int LINE_W  = 5,
    parameter int NUM_COM = 4,
    parameter int COM_W   = $clog2(NUM_COM)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_tick,
    input  logic              master,
    input  logic              fr_in,
    input  logic [LINE_W-1:0] start_line,
    input  logic              duty4,
    input  logic              psave,
    output logic [LINE_W-1:0] line_q,
    output logic [COM_W-1:0]  com_q,
    output logic              fr_q
);
    localparam logic [COM_W-1:0] LAST_LONG  = COM_W'(NUM_COM - 1);
    localparam logic [COM_W-1:0] LAST_SHORT = COM_W'(NUM_COM - 2);

    logic [COM_W-1:0] last_idx;
    logic             wrap;
    logic             slave_edge;

    assign last_idx   = duty4 ? LAST_LONG : LAST_SHORT;
    assign wrap       = (com_q >= last_idx);
    assign slave_edge = !master && (fr_in != fr_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= start_line;
            com_q  <= '0;
            fr_q   <= 1'b0;
        end else if (!psave) begin
            if (!master) fr_q <= fr_in;
            if (slave_edge) begin
                com_q  <= '0;
                line_q <= start_line;
            end else if (line_tick) begin
                if (wrap) begin
                    com_q  <= '0;
                    line_q <= start_line;
                    if (master) fr_q <= ~fr_q;
                end else begin
                    com_q  <= com_q + COM_W'(1);
                    line_q <= line_q + LINE_W'(1);
                end
            end
        end
    end

    assert_reload_R2: assert property (@(posedge clk) disable iff (rst)
        (!psave && line_tick && wrap && !slave_edge) |=> (line_q == $past(start_line)));

    assert_fr_toggle_R4: assert property (@(posedge clk) disable iff (rst)
        (master && !psave && line_tick && wrap) |=> (fr_q != $past(fr_q)));

    assert_fr_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (master && !(!psave && line_tick && wrap)) |=> $stable(fr_q));

    assert_slave_follow_R5: assert property (@(posedge clk) disable iff (rst)
        (!master && !psave) |=> (fr_q == $past(fr_in)));

    assert_psave_hold_R11: assert property (@(posedge clk) disable iff (rst)
        psave |=> ($stable(line_q) && $stable(com_q) && $stable(fr_q)));

endmodule

// File: rtl/lcd_row_latch.sv
module lcd_row_latch
    import lcd_scan_pkg::*;
#(
    parameter int NUM_SEG = 73,
    parameter int NUM_COL = 80,
    parameter int NUM_COM = 4,
    parameter int COM_W   = $clog2(NUM_COM)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_COL-1:0] row_i,
    input  logic [COM_W-1:0]   com_idx,
    input  logic               fr,
    input  logic               disp_on,
    input  logic               static_en,
    input  logic               reverse,
    input  logic               psave,
    output logic [NUM_SEG-1:0] seg_bits_q,
    output logic [NUM_COM-1:0] com_sel_q,
    output drive_ctl_t         ctl_q
);
    logic [NUM_SEG-1:0] col_bit;
    logic [NUM_COM-1:0] sel_d;
    logic               shown;

    assign shown = disp_on || static_en;

    for (genvar n = 0; n < NUM_SEG; n++) begin : g_col
        assign col_bit[n] = reverse ? row_i[NUM_COL-1-n] : row_i[n];
    end

    for (genvar k = 0; k < NUM_COM; k++) begin : g_sel
        assign sel_d[k] = static_en || (com_idx == COM_W'(k));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_bits_q <= '0;
            com_sel_q  <= '0;
            ctl_q      <= '{fr: 1'b0, blank: 1'b1};
        end else begin
            seg_bits_q <= shown ? col_bit : '0;
            com_sel_q  <= sel_d;
            ctl_q      <= '{fr: fr, blank: psave};
        end
    end

    assert_single_com_R3: assert property (@(posedge clk) disable iff (rst)
        !static_en |=> ($countones(com_sel_q) == 1));

endmodule

// File: rtl/lcd_level_encode.sv
module lcd_level_encode
    import lcd_scan_pkg::*;
#(
    parameter int NUM_SEG = 73,
    parameter int NUM_COM = 4
) (
    input  logic [NUM_SEG-1:0]   seg_bits,
    input  logic [NUM_COM-1:0]   com_sel,
    input  drive_ctl_t           ctl,
    output logic [2*NUM_SEG-1:0] seg_lvl,
    output logic [2*NUM_COM-1:0] com_lvl
);
    for (genvar n = 0; n < NUM_SEG; n++) begin : g_seg
        assign seg_lvl[2*n +: 2] = ctl.blank ? LVL_VDD : seg_level(ctl.fr, seg_bits[n]);
    end

    for (genvar k = 0; k < NUM_COM; k++) begin : g_com
        assign com_lvl[2*k +: 2] = ctl.blank ? LVL_VDD : com_level(ctl.fr, com_sel[k]);
    end

endmodule

// File: rtl/lcd_seg_scan.sv
module lcd_seg_scan
    import lcd_scan_pkg::*;
#(
    parameter int NUM_SEG = 73,
    parameter int NUM_COM = 4,
    parameter int NUM_COL = 80,
    parameter int LINE_W  = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 line_tick_i,
    input  logic                 master_i,
    input  logic                 fr_i,
    input  logic [LINE_W-1:0]    start_line_i,
    input  logic                 duty4_i,
    input  logic                 disp_on_i,
    input  logic                 static_i,
    input  logic                 reverse_i,
    output logic [LINE_W-1:0]    rd_line_o,
    input  logic [NUM_COL-1:0]   rd_row_i,
    output logic                 fr_o,
    output logic [2*NUM_SEG-1:0] seg_lvl_o,
    output logic [2*NUM_COM-1:0] com_lvl_o
);
    localparam int COM_W = $clog2(NUM_COM);

    logic               psave;
    logic [COM_W-1:0]   com_idx;
    logic               fr_int;
    logic [NUM_SEG-1:0] seg_bits;
    logic [NUM_COM-1:0] com_sel;
    drive_ctl_t         ctl;

    assign psave = static_i && !disp_on_i;
    assign fr_o  = ctl.fr;

    lcd_scan_timing #(.LINE_W(LINE_W), .NUM_COM(NUM_COM), .COM_W(COM_W)) timing_i (
        .clk(clk), .rst(rst), .line_tick(line_tick_i), .master(master_i),
        .fr_in(fr_i), .start_line(start_line_i), .duty4(duty4_i), .psave(psave),
        .line_q(rd_line_o), .com_q(com_idx), .fr_q(fr_int)
    );

    lcd_row_latch #(.NUM_SEG(NUM_SEG), .NUM_COL(NUM_COL), .NUM_COM(NUM_COM), .COM_W(COM_W)) latch_i (
        .clk(clk), .rst(rst), .row_i(rd_row_i), .com_idx(com_idx), .fr(fr_int),
        .disp_on(disp_on_i), .static_en(static_i), .reverse(reverse_i), .psave(psave),
        .seg_bits_q(seg_bits), .com_sel_q(com_sel), .ctl_q(ctl)
    );

    lcd_level_encode #(.NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM)) encode_i (
        .seg_bits(seg_bits), .com_sel(com_sel), .ctl(ctl),
        .seg_lvl(seg_lvl_o), .com_lvl(com_lvl_o)
    );

    assert_psave_blank_R11: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && psave) |-> (seg_lvl_o == '0 && com_lvl_o == '0));

    assert_static_all_R9: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && static_i && disp_on_i) |->
            ((fr_o && com_lvl_o == {NUM_COM{2'b11}}) || (!fr_o && com_lvl_o == '0)));

endmodule

// File: tb/lcd_seg_scan_tb_top.sv
module lcd_seg_scan_tb_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick = 1'b0;
    logic         master = 1'b1;
    logic         fr_in = 1'b0;
    logic [4:0]   start = 5'd5;
    logic         duty4 = 1'b1;
    logic         disp = 1'b1;
    logic         stat = 1'b0;
    logic         rev = 1'b0;
    logic [4:0]   rd_line;
    logic [79:0]  rd_row;
    logic         fr_o;
    logic [145:0] seg_lvl;
    logic [7:0]   com_lvl;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int mline, mcom;
    logic mfr;

    always #5 clk = ~clk;

    function automatic logic [79:0] row_pat(input int line);
        logic [79:0] r;
        for (int c = 0; c < 80; c++) r[c] = ((c * 5 + line * 3) % 7) < 3;
        return r;
    endfunction

    assign rd_row = row_pat(int'(rd_line));

    lcd_seg_scan dut_i (
        .clk(clk), .rst(rst), .line_tick_i(tick), .master_i(master), .fr_i(fr_in),
        .start_line_i(start), .duty4_i(duty4), .disp_on_i(disp), .static_i(stat),
        .reverse_i(rev), .rd_line_o(rd_line), .rd_row_i(rd_row), .fr_o(fr_o),
        .seg_lvl_o(seg_lvl), .com_lvl_o(com_lvl)
    );

    typedef struct packed {
        logic [4:0] st;
        logic       d4;
        logic       on;
        logic       sd;
        logic       rv;
        logic [3:0] n;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{st: 5'd5,  d4: 1'b1, on: 1'b1, sd: 1'b0, rv: 1'b0, n: 4'd6},
        '{st: 5'd30, d4: 1'b1, on: 1'b1, sd: 1'b0, rv: 1'b1, n: 4'd5},
        '{st: 5'd2,  d4: 1'b0, on: 1'b1, sd: 1'b0, rv: 1'b0, n: 4'd5},
        '{st: 5'd9,  d4: 1'b1, on: 1'b0, sd: 1'b0, rv: 1'b0, n: 4'd3},
        '{st: 5'd12, d4: 1'b1, on: 1'b1, sd: 1'b1, rv: 1'b0, n: 4'd3},
        '{st: 5'd12, d4: 1'b0, on: 1'b0, sd: 1'b1, rv: 1'b0, n: 4'd4},
        '{st: 5'd7,  d4: 1'b1, on: 1'b1, sd: 1'b0, rv: 1'b1, n: 4'd4}
    };

    function automatic logic [145:0] exp_seg();
        logic [145:0] e;
        logic [79:0]  r;
        r = row_pat(mline);
        e = '0;
        if (stat && !disp) return e;
        for (int n = 0; n < 73; n++) begin
            logic d;
            d = (disp || stat) ? r[rev ? 79 - n : n] : 1'b0;
            e[2*n +: 2] = mfr ? (d ? 2'd0 : 2'd2) : (d ? 2'd3 : 2'd1);
        end
        return e;
    endfunction

    function automatic logic [7:0] exp_com();
        logic [7:0] e;
        e = '0;
        if (stat && !disp) return e;
        for (int k = 0; k < 4; k++) begin
            logic s;
            s = stat || (k == mcom);
            e[2*k +: 2] = mfr ? (s ? 2'd3 : 2'd1) : (s ? 2'd0 : 2'd2);
        end
        return e;
    endfunction

    task automatic chk(input string tag, input logic [145:0] act, input logic [145:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({"R2 line ", tag}, 146'(rd_line), 146'(mline[4:0]));
        chk({"R4/R5 frame ", tag}, 146'(fr_o), 146'(mfr));
        chk({"R3/R7 commons ", tag}, 146'(com_lvl), 146'(exp_com()));
        chk({"R6 segments ", tag}, seg_lvl, exp_seg());
    endtask

    task automatic model_tick();
        int last;
        if (stat && !disp) return;
        last = duty4 ? 3 : 2;
        if (mcom >= last) begin
            mcom = 0;
            mline = start;
            if (master) mfr = ~mfr;
        end else begin
            mcom++;
            mline = (mline + 1) % 32;
        end
    endtask

    task automatic do_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        model_tick();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset segments", seg_lvl, '0);
        chk("R1 reset commons", 146'(com_lvl), '0);
        chk("R1 reset frame", 146'(fr_o), '0);
        chk("R1 reset line", 146'(rd_line), 146'(5'd5));
        rst = 1'b0;
        mline = 5; mcom = 0; mfr = 1'b0;
        repeat (2) @(negedge clk);
        check_all("after reset R6 R7");

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            start = VECS[i].st; duty4 = VECS[i].d4; disp = VECS[i].on;
            stat = VECS[i].sd; rev = VECS[i].rv;
            repeat (2) @(negedge clk);
            check_all(stat && !disp ? "R11 power save" : stat ? "R9 static" :
                      !disp ? "R10 display off" : rev ? "R8 reversed" : "R3 normal");
            for (int t = 0; t < int'(VECS[i].n); t++) begin
                do_tick();
                check_all(stat && !disp ? "R11 power save hold" : stat ? "R9 static scan" :
                          !disp ? "R10 display off scan" : rev ? "R8 reversed scan" :
                          duty4 ? "R2 four-line frame" : "R3 three-line frame");
            end
        end

        // R5 slave mode: follow the master frame and restart on its edge
        @(negedge clk);
        master = 1'b0; fr_in = mfr; start = 5'd20; duty4 = 1'b1;
        repeat (2) @(negedge clk);
        check_all("R5 slave entry");
        do_tick();
        do_tick();
        check_all("R5 slave mid-frame");
        @(negedge clk);
        fr_in = ~fr_in;
        mfr = fr_in; mcom = 0; mline = start;
        repeat (2) @(negedge clk);
        check_all("R5 slave restart");
        for (int t = 0; t < 5; t++) begin
            do_tick();
            check_all("R5 slave wrap keeps frame");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule